// File: doc/BRIEF.md
# Synthesizer Divider Power-Down Controller

This block holds the reference divider and the feedback divider of a frequency synthesizer, together with a small phase/frequency detector that produces up and down pump pulses. A serial control port loads two mode bits: a power-down request and a counter-reset selector. The two bits together choose between normal running, a synchronous power-down and an immediate power-down. In synchronous power-down, entry waits until any pump pulse in progress has ended. In immediate power-down, entry does not wait. While powered down, both dividers are parked at zero and the detector is cleared. On wake-up both dividers count from zero on the same cycle, so the phase relation between them is known.

All inputs are synchronous to `clk`. `ref_tick` and `fb_tick` are one-cycle events that stand for reference and VCO edges. A rising edge on `ser_clk` shifts `ser_data` in. A rising edge on `ser_latch` commits the shifted bits. A three-state machine orders power-down entry and exit. The states are `ST_RUN` (dividers active), `ST_DRAIN` (synchronous request waiting for the pump to go idle) and `ST_OFF` (powered down). The transitions are:
- RUN→OFF on an immediate request, or on a synchronous request with the pump idle.
- RUN→DRAIN on a synchronous request with the pump busy.
- DRAIN→OFF when the pump goes idle or the request becomes immediate.
- DRAIN→RUN when the request is withdrawn.
- OFF→RUN when the request is withdrawn.

Top module: `pll_pd_ctrl`

## Requirements
- R1: Bits are shifted in MSB first on each detected rising edge of `ser_clk`. Bit 0 is the last bit shifted. Shifting has no effect on the mode until a rising edge of `ser_latch` commits the word. In the committed word, bit 1 is the power-down request and bit 2 is the counter-reset selector.
- R2: While running, each divider advances by one on each of its ticks and wraps from DIV-1 to 0. The defaults are R_DIV=4 and N_DIV=6.
- R3: A reference wrap sets `pump_up` and a feedback wrap sets `pump_dn`, each from the next clock. When both would be high, both clear on that clock, so the two never assert together.
- R4: With power-down=1 and counter-reset=1, `powered_down` rises on the clock after the control word updates, even while a pump pulse is active.
- R5: With power-down=1 and counter-reset=0 while a pump pulse is active, `powered_down` stays low. It rises on the clock after the cycle in which both pump outputs are low.
- R6: With power-down=1 and counter-reset=0 while no pump pulse is active, `powered_down` rises on the clock after the control word updates.
- R7: One clock after entering power-down, both divider counts and both pump outputs are zero. They stay zero while ticks arrive.
- R8: With power-down=0, `powered_down` falls on the clock after the control word updates. Both dividers then start from zero together.
- R9: The serial port keeps shifting and latching while powered down, so a new mode takes effect from that state.
- R10: While waiting in `ST_DRAIN`, committing counter-reset=1 enters power-down on the next clock, and committing power-down=0 returns to `ST_RUN` without powering down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| ser_latch | input | 1 | Rising edge commits the shifted bits |
| ref_tick | input | 1 | One-cycle reference edge event |
| fb_tick | input | 1 | One-cycle feedback (VCO) edge event |
| pump_up | output | 1 | Detector up pulse |
| pump_dn | output | 1 | Detector down pulse |
| r_count | output | $clog2(R_DIV) | Reference divider count |
| n_count | output | $clog2(N_DIV) | Feedback divider count |
| powered_down | output | 1 | High while dividers are parked |

## Verification
The assertions assume that all inputs are already synchronous to `clk` and change only once per cycle. They also assume that a serial clock edge and a latch edge never land in the same cycle, and that tick inputs are single-cycle events. The bench drives every input one time unit after a rising edge and never raises `ser_clk` and `ser_latch` together. Each serial bit is held for two clocks so that every edge on `ser_clk` is seen exactly once. The gating rule for synchronous entry assumes the pump pulse eventually ends. The bench guarantees this by issuing the matching feedback ticks.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2
    } pd_state_t;
endpackage

// File: rtl/pd_serial_ctrl.sv
module pd_serial_ctrl #(
    parameter int PD_BIT   = 1,
    parameter int CRST_BIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    input  logic ser_latch,
    output logic pd_req,
    output logic crst_req
);
    localparam int TOP = (PD_BIT > CRST_BIT) ? PD_BIT : CRST_BIT;

    logic [TOP:0] shreg;
    logic         sclk_q;
    logic         latch_q;
    logic         shift_en;
    logic         commit;

    assign shift_en = ser_clk & ~sclk_q;
    assign commit   = ser_latch & ~latch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            sclk_q   <= 1'b0;
            latch_q  <= 1'b0;
            pd_req   <= 1'b0;
            crst_req <= 1'b0;
        end else begin
            sclk_q  <= ser_clk;
            latch_q <= ser_latch;
            if (shift_en) begin
                shreg <= {shreg[TOP-1:0], ser_data};
            end
            if (commit) begin
                pd_req   <= shreg[PD_BIT];
                crst_req <= shreg[CRST_BIT];
            end
        end
    end

    // R1: the mode bits only move on a latch edge
    a_r1_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> $stable(pd_req) && $stable(crst_req));
endmodule

// File: rtl/pd_div_counter.sv
module pd_div_counter #(
    parameter int DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   hold,
    output logic [$clog2(DIV)-1:0] cnt,
    output logic                   term
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    assign term = tick & ~hold & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R2: the count never leaves its range
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/pd_phase_det.sv
module pd_phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_term,
    input  logic fb_term,
    input  logic clear,
    output logic up,
    output logic dn
);
    logic up_nx;
    logic dn_nx;

    always_comb begin
        up_nx = up | ref_term;
        dn_nx = dn | fb_term;
        if ((up_nx && dn_nx) || clear) begin
            up_nx = 1'b0;
            dn_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx;
            dn <= dn_nx;
        end
    end

    // R3: a reference wrap with no feedback wrap raises up next cycle
    a_r3_up_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_term && !fb_term && !dn && !clear) |=> up);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));
endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
    import pll_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic crst_req,
    input  logic pump_busy,
    output logic powered_down,
    output logic hold
);
    pd_state_t state;
    pd_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (pd_req) begin
                    state_nx = (crst_req || !pump_busy) ? ST_OFF : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (!pd_req) begin
                    state_nx = ST_RUN;
                end else if (crst_req || !pump_busy) begin
                    state_nx = ST_OFF;
                end
            end
            ST_OFF: begin
                if (!pd_req) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        powered_down = (state == ST_OFF);
        hold         = (state == ST_OFF);
    end

    // R4: an immediate request lands on the next clock from any state
    a_r4_immediate_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_req && crst_req) |=> (state == ST_OFF));
    // R10: withdrawing the request while draining goes back to running
    a_r10_drain_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !pd_req) |=> (state == ST_RUN));
endmodule

// File: rtl/pll_pd_ctrl.sv
module pll_pd_ctrl #(
    parameter int R_DIV    = 4,
    parameter int N_DIV    = 6,
    parameter int PD_BIT   = 1,
    parameter int CRST_BIT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_data,
    input  logic                     ser_latch,
    input  logic                     ref_tick,
    input  logic                     fb_tick,
    output logic                     pump_up,
    output logic                     pump_dn,
    output logic [$clog2(R_DIV)-1:0] r_count,
    output logic [$clog2(N_DIV)-1:0] n_count,
    output logic                     powered_down
);
    logic pd_req;
    logic crst_req;
    logic hold;
    logic ref_term;
    logic fb_term;

    pd_serial_ctrl #(.PD_BIT(PD_BIT), .CRST_BIT(CRST_BIT)) u_serial (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .pd_req(pd_req), .crst_req(crst_req));

    pd_div_counter #(.DIV(R_DIV)) u_rdiv (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .hold(hold),
        .cnt(r_count), .term(ref_term));

    pd_div_counter #(.DIV(N_DIV)) u_ndiv (
        .clk(clk), .rst_n(rst_n), .tick(fb_tick), .hold(hold),
        .cnt(n_count), .term(fb_term));

    pd_phase_det u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_term(ref_term), .fb_term(fb_term),
        .clear(hold), .up(pump_up), .dn(pump_dn));

    pd_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .crst_req(crst_req),
        .pump_busy(pump_up | pump_dn), .powered_down(powered_down), .hold(hold));

    // R5: synchronous entry only after an idle pump cycle
    a_r5_gated_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered_down) |-> ((!$past(pump_up) && !$past(pump_dn)) || $past(crst_req)));
    // R7: parked dividers and quiet pump after the first powered-down cycle
    a_r7_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_down && $past(powered_down)) |->
            (r_count == '0 && n_count == '0 && !pump_up && !pump_dn));
    // R8: wake-up starts both dividers from zero
    a_r8_wake_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powered_down) |-> (r_count == '0 && n_count == '0));
endmodule

// File: tb/pll_pd_ctrl_tb.sv
`timescale 1ns/1ps
module pll_pd_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_latch = 1'b0;
    logic       ref_tick = 1'b0;
    logic       fb_tick = 1'b0;
    logic       pump_up;
    logic       pump_dn;
    logic [1:0] r_count;
    logic [2:0] n_count;
    logic       powered_down;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pll_pd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .pump_up(pump_up), .pump_dn(pump_dn), .r_count(r_count),
        .n_count(n_count), .powered_down(powered_down));

    // {ref_tick, fb_tick, r_count[3:0], n_count[3:0], up, dn}
    localparam logic [11:0] VEC [24] = '{
        12'b1_1_0001_0001_0_0, 12'b1_0_0010_0001_0_0, 12'b1_1_0011_0010_0_0,
        12'b1_0_0000_0010_1_0, 12'b0_1_0000_0011_1_0, 12'b0_1_0000_0100_1_0,
        12'b0_1_0000_0101_1_0, 12'b0_1_0000_0000_0_0, 12'b0_1_0000_0001_0_0,
        12'b1_0_0001_0001_0_0, 12'b0_1_0001_0010_0_0, 12'b0_1_0001_0011_0_0,
        12'b0_1_0001_0100_0_0, 12'b0_1_0001_0101_0_0, 12'b0_1_0001_0000_0_1,
        12'b1_0_0010_0000_0_1, 12'b1_0_0011_0000_0_1, 12'b1_0_0000_0000_0_0,
        12'b1_1_0001_0001_0_0, 12'b1_1_0010_0010_0_0, 12'b1_1_0011_0011_0_0,
        12'b0_1_0011_0100_0_0, 12'b0_1_0011_0101_0_0, 12'b1_1_0000_0000_0_0
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic shift_word(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) begin
            ser_data = w[i];
            ser_clk  = 1'b0;
            step();
            ser_clk  = 1'b1;
            step();
        end
        ser_clk = 1'b0;
        step();
    endtask

    task automatic latch_word();
        ser_latch = 1'b1;
        step();
        ser_latch = 1'b0;
    endtask

    task automatic ticks(input int n, input logic r, input logic f);
        for (int i = 0; i < n; i++) begin
            ref_tick = r;
            fb_tick  = f;
            step();
        end
        ref_tick = 1'b0;
        fb_tick  = 1'b0;
    endtask

    task automatic wake();
        shift_word(8'h00);
        latch_word();
        step();
        chk("R8 wake powered_down", powered_down, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R2 reset r_count", r_count, 0);
        chk("R2 reset n_count", n_count, 0);
        chk("R3 reset up/dn", {pump_up, pump_dn}, 0);
        chk("R7 reset powered_down", powered_down, 0);

        // R2 / R3: vector walk in run mode
        for (int v = 0; v < 24; v++) begin
            ref_tick = VEC[v][11];
            fb_tick  = VEC[v][10];
            step();
            chk("R2 table r_count", r_count, VEC[v][9:6]);
            chk("R2 table n_count", n_count, VEC[v][5:2]);
            chk("R3 table pump_up", pump_up, VEC[v][1]);
            chk("R3 table pump_dn", pump_dn, VEC[v][0]);
        end
        ref_tick = 1'b0;
        fb_tick  = 1'b0;

        // R4: immediate entry while a pump pulse is active
        ticks(5, 1'b1, 1'b0);
        chk("R4 pulse active before request", pump_up, 1);
        shift_word(8'h06);
        repeat (3) step();
        chk("R1 no effect before latch", powered_down, 0);
        latch_word();
        chk("R4 not yet down at word update", powered_down, 0);
        step();
        chk("R4 down one clock later", powered_down, 1);
        step();
        chk("R7 r_count parked", r_count, 0);
        chk("R7 pump_up cleared", pump_up, 0);
        for (int i = 0; i < 5; i++) begin
            ref_tick = 1'b1;
            fb_tick  = 1'b1;
            step();
            chk("R7 r_count held", r_count, 0);
            chk("R7 n_count held", n_count, 0);
            chk("R7 pump quiet", {pump_up, pump_dn}, 0);
        end
        ref_tick = 1'b0;
        fb_tick  = 1'b0;

        // R9: reload while down, then R8 wake
        shift_word(8'h02);
        latch_word();
        repeat (3) step();
        chk("R9 still down after reload", powered_down, 1);
        shift_word(8'h00);
        latch_word();
        chk("R8 still down at word update", powered_down, 1);
        step();
        chk("R8 up one clock later", powered_down, 0);
        chk("R8 r_count from zero", r_count, 0);
        chk("R8 n_count from zero", n_count, 0);
        ticks(3, 1'b1, 1'b1);
        chk("R8 r_count aligned", r_count, 3);
        chk("R8 n_count aligned", n_count, 3);

        // R6: synchronous request with idle pump
        shift_word(8'h02);
        latch_word();
        chk("R6 not yet down at word update", powered_down, 0);
        step();
        chk("R6 down one clock later", powered_down, 1);
        wake();

        // R5: synchronous request deferred until the pulse ends
        ticks(4, 1'b1, 1'b0);
        chk("R5 pulse active", pump_up, 1);
        shift_word(8'h02);
        latch_word();
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R5 deferred while pulse", powered_down, 0);
        end
        for (int i = 0; i < 6; i++) begin
            fb_tick = 1'b1;
            step();
            chk("R5 deferred during feedback ticks", powered_down, 0);
        end
        fb_tick = 1'b0;
        chk("R5 pulse ended", pump_up, 0);
        step();
        chk("R5 down after idle cycle", powered_down, 1);
        wake();

        // R10: counter-reset committed while draining
        ticks(4, 1'b1, 1'b0);
        shift_word(8'h02);
        latch_word();
        repeat (2) step();
        chk("R10 draining not down", powered_down, 0);
        shift_word(8'h06);
        latch_word();
        chk("R10 not down at word update", powered_down, 0);
        step();
        chk("R10 immediate from drain", powered_down, 1);
        wake();

        // R10: request withdrawn while draining
        ticks(4, 1'b1, 1'b0);
        shift_word(8'h02);
        latch_word();
        repeat (2) step();
        shift_word(8'h00);
        latch_word();
        repeat (2) step();
        ticks(6, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R10 withdrawn stays running", powered_down, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule